// File: doc/BRIEF.md
# Prioritized Fast Interrupt Controller

This block collects up to eight fast interrupt request lines and presents one interrupt line to the processor. A request is latched as pending when its input rises. Each input has its own 3-bit priority code, and a smaller code means more urgent. The block asserts the interrupt output only when a pending request is more urgent than everything already being serviced. This allows handlers to nest.

Software talks to the block through a word-addressed register port. Reading the acknowledge register returns the number of the winning input, with every upper bit set to one. The same read moves that input from pending to in service. When nothing can be granted, the read returns all ones. A write of any data to the end-of-interrupt register retires the most urgent in-service entry. A write to the clear register discards one pending request by number. The in-service set can be read at its own offset, and each priority code has a read/write register.

Top module: `fiq_ctrl`

## Requirements
- R1: After reset every priority register reads 7, the in-service register reads 0, nothing is pending and `fiq_o` is low.
- R2: A request becomes pending only on a 0-to-1 transition of its input. A level held high does not pend it again, and a falling input does not cancel a pending request.
- R3: A read at byte offset 0x18 returns the granted input number in bits 2:0 with bits 31:3 all ones. When no request can be granted, the read returns 0xFFFF_FFFF.
- R4: Among grantable requests, the lowest priority code wins. On equal codes, the lowest input number wins.
- R5: A granting acknowledge read clears that input's pending bit and sets its in-service bit in the same clock cycle.
- R6: `fiq_o` is high exactly when some pending request has a priority code strictly lower than the lowest code among in-service inputs, or when any request is pending and nothing is in service.
- R7: A write of any data to offset 0x28 clears the in-service bit with the lowest priority code, taking the lower input number on a tie. When nothing is in service, the write has no effect.
- R8: A write to offset 0x1C deletes the pending request whose input number is in wdata bits 2:0.
- R9: The priority code for input i sits at offset 0x2C + 4*i in bits 2:0. The bits above read as zero, and writes to them are dropped.
- R10: The in-service register at offset 0x4C shows input i in bit i and is read-only. Writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 8 | Fast request lines, bit i is input i |
| bus_sel_i | input | 1 | Register access strobe, one access per cycle |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 8 | Byte offset of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid in the cycle of the strobe |
| fiq_o | output | 1 | Interrupt to the processor |

## Verification
On every cycle, the assertions check the following:
- the all-ones padding of acknowledge data;
- the agreement between `fiq_o` and whether an acknowledge would return a real vector;
- that a granting read adds exactly one in-service entry;
- that end-of-interrupt removes exactly one entry, or none when the set is empty;
- that the in-service set never moves without an acknowledge or end-of-interrupt.

Only the directed scenarios can show which input wins a tie or a priority contest, the nesting order of retirement, edge-only capture, the effect of a clear write, and the register layout.

// File: rtl/fiq_pkg.sv
package fiq_pkg;
  localparam logic [7:0] OFS_ACK   = 8'h18;
  localparam logic [7:0] OFS_CLR   = 8'h1C;
  localparam logic [7:0] OFS_EOI   = 8'h28;
  localparam logic [7:0] OFS_PRIO0 = 8'h2C;
  localparam logic [7:0] OFS_SVC   = 8'h4C;

  typedef enum logic [2:0] {
    ACC_NONE,
    ACC_ACK,
    ACC_CLR,
    ACC_EOI,
    ACC_PRIO,
    ACC_SVC
  } acc_e;
endpackage

// File: rtl/fiq_pick.sv
// Selects the most urgent member of a mask: lowest code, then lowest index.
module fiq_pick #(
  parameter int NUM_IN = 8,
  parameter int PRIO_W = 3,
  localparam int IDX_W = $clog2(NUM_IN)
) (
  input  logic [NUM_IN-1:0]             mask_i,
  input  logic [NUM_IN-1:0][PRIO_W-1:0] prio_i,
  output logic                          hit_o,
  output logic [IDX_W-1:0]              idx_o,
  output logic [PRIO_W-1:0]             lvl_o
);
  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    lvl_o = '1;
    for (int i = NUM_IN - 1; i >= 0; i--) begin
      if (mask_i[i] && (!hit_o || prio_i[i] <= lvl_o)) begin
        hit_o = 1'b1;
        idx_o = IDX_W'(i);
        lvl_o = prio_i[i];
      end
    end
  end
endmodule

// File: rtl/fiq_capture.sv
// Rising-edge request capture into the pending set.
module fiq_capture #(
  parameter int NUM_IN = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_IN-1:0] req_i,
  input  logic [NUM_IN-1:0] clr_i,
  output logic [NUM_IN-1:0] pend_o
);
  logic [NUM_IN-1:0] req_q, pend_q, pend_d, rise;

  always_comb begin
    rise   = req_i & ~req_q;
    pend_d = (pend_q & ~clr_i) | rise;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= '0;
      pend_q <= '0;
    end else begin
      req_q  <= req_i;
      pend_q <= pend_d;
    end
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/fiq_service.sv
// In-service set: set by acknowledge, cleared by end-of-interrupt.
module fiq_service #(
  parameter int NUM_IN = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_IN-1:0] set_i,
  input  logic [NUM_IN-1:0] clr_i,
  output logic [NUM_IN-1:0] svc_o
);
  logic [NUM_IN-1:0] svc_q, svc_d;
  logic              svc_en;

  always_comb begin
    svc_en = |(set_i | clr_i);
    svc_d  = (svc_q & ~clr_i) | set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      svc_q <= '0;
    else if (svc_en) svc_q <= svc_d;
  end

  assign svc_o = svc_q;
endmodule

// File: rtl/fiq_ctrl.sv
module fiq_ctrl #(
  parameter int NUM_IN = 8,
  parameter int PRIO_W = 3,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_IN-1:0] req_i,
  input  logic              bus_sel_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              fiq_o
);
  import fiq_pkg::*;
  localparam int IDX_W = $clog2(NUM_IN);

  logic [NUM_IN-1:0][PRIO_W-1:0] prio_q, prio_d;
  logic [NUM_IN-1:0]             prio_hit, prio_we;
  logic [NUM_IN-1:0]             pend, svc, eligible;
  logic [NUM_IN-1:0]             pend_clr, svc_set, svc_clr;
  logic                          win_hit, svc_hit;
  logic [IDX_W-1:0]              win_idx, svc_idx, prio_idx;
  logic [PRIO_W-1:0]             win_lvl, svc_lvl;
  acc_e                          acc;
  logic                          ack_take;
  logic                          unused_wdata;

  assign unused_wdata = ^bus_wdata_i;

  // Register decode
  for (genvar i = 0; i < NUM_IN; i++) begin : g_prio_dec
    assign prio_hit[i] = (bus_addr_i == ADDR_W'(OFS_PRIO0) + ADDR_W'(4 * i));
  end

  always_comb begin
    acc      = ACC_NONE;
    prio_idx = '0;
    for (int i = 0; i < NUM_IN; i++)
      if (prio_hit[i]) prio_idx = IDX_W'(i);
    if (bus_sel_i) begin
      if      (bus_addr_i == ADDR_W'(OFS_ACK)) acc = ACC_ACK;
      else if (bus_addr_i == ADDR_W'(OFS_CLR)) acc = ACC_CLR;
      else if (bus_addr_i == ADDR_W'(OFS_EOI)) acc = ACC_EOI;
      else if (bus_addr_i == ADDR_W'(OFS_SVC)) acc = ACC_SVC;
      else if (|prio_hit)                      acc = ACC_PRIO;
    end
  end

  // Priority registers
  always_comb begin
    prio_we = '0;
    prio_d  = prio_q;
    if (acc == ACC_PRIO && bus_we_i) begin
      prio_we[prio_idx] = 1'b1;
      prio_d[prio_idx]  = bus_wdata_i[PRIO_W-1:0];
    end
  end

  for (genvar i = 0; i < NUM_IN; i++) begin : g_prio_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          prio_q[i] <= '1;
      else if (prio_we[i]) prio_q[i] <= prio_d[i];
    end
  end

  // Arbitration: service level, then eligible pending requests
  fiq_pick #(.NUM_IN(NUM_IN), .PRIO_W(PRIO_W)) u_svc_pick (
    .mask_i(svc), .prio_i(prio_q),
    .hit_o(svc_hit), .idx_o(svc_idx), .lvl_o(svc_lvl)
  );

  for (genvar i = 0; i < NUM_IN; i++) begin : g_elig
    assign eligible[i] = pend[i] && (!svc_hit || prio_q[i] < svc_lvl);
  end

  fiq_pick #(.NUM_IN(NUM_IN), .PRIO_W(PRIO_W)) u_win_pick (
    .mask_i(eligible), .prio_i(prio_q),
    .hit_o(win_hit), .idx_o(win_idx), .lvl_o(win_lvl)
  );

  // Handshake side effects
  always_comb begin
    ack_take = (acc == ACC_ACK) && !bus_we_i && win_hit;
    svc_set  = ack_take ? (NUM_IN'(1) << win_idx) : '0;
    svc_clr  = (acc == ACC_EOI && bus_we_i && svc_hit) ? (NUM_IN'(1) << svc_idx) : '0;
    pend_clr = svc_set;
    if (acc == ACC_CLR && bus_we_i)
      pend_clr = pend_clr | (NUM_IN'(1) << bus_wdata_i[IDX_W-1:0]);
  end

  fiq_capture #(.NUM_IN(NUM_IN)) u_capture (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .clr_i(pend_clr), .pend_o(pend)
  );

  fiq_service #(.NUM_IN(NUM_IN)) u_service (
    .clk(clk), .rst_n(rst_n), .set_i(svc_set), .clr_i(svc_clr), .svc_o(svc)
  );

  // Read data
  always_comb begin
    bus_rdata_o = '0;
    if (!bus_we_i) begin
      unique case (acc)
        ACC_ACK:  bus_rdata_o = win_hit ? {{(DATA_W-IDX_W){1'b1}}, win_idx} : '1;
        ACC_PRIO: bus_rdata_o = DATA_W'(prio_q[prio_idx]);
        ACC_SVC:  bus_rdata_o = DATA_W'(svc);
        default:  bus_rdata_o = '0;
      endcase
    end
  end

  assign fiq_o = win_hit;
endmodule

// File: rtl/fiq_ctrl_chk.sv
module fiq_ctrl_chk #(
  parameter int NUM_IN = 8,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel_i,
  input logic              bus_we_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic [DATA_W-1:0] bus_rdata_o,
  input logic              fiq_o,
  input logic [NUM_IN-1:0] svc
);
  import fiq_pkg::*;
  localparam int IDX_W = $clog2(NUM_IN);

  logic ack_rd, eoi_wr;
  assign ack_rd = bus_sel_i && !bus_we_i && bus_addr_i == ADDR_W'(OFS_ACK);
  assign eoi_wr = bus_sel_i && bus_we_i && bus_addr_i == ADDR_W'(OFS_EOI);

  p_ack_pad_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ack_rd |-> &bus_rdata_o[DATA_W-1:IDX_W]);

  p_idle_default_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_rd && !fiq_o) |-> &bus_rdata_o);

  p_grant_adds_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_rd && fiq_o) |=> $countones(svc) == $past($countones(svc)) + 1);

  p_grant_not_blocked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_rd && fiq_o) |-> !svc[bus_rdata_o[IDX_W-1:0]]);

  p_eoi_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_wr && svc == '0) |=> svc == '0);

  p_eoi_retire_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_wr && svc != '0) |=> $countones(svc) + 1 == $past($countones(svc)));

  p_svc_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(ack_rd || eoi_wr) |=> $stable(svc));
endmodule

bind fiq_ctrl fiq_ctrl_chk #(.NUM_IN(NUM_IN), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel_i(bus_sel_i), .bus_we_i(bus_we_i),
  .bus_addr_i(bus_addr_i), .bus_rdata_o(bus_rdata_o), .fiq_o(fiq_o), .svc(svc)
);

// File: tb/tb_fiq_ctrl.sv
module tb_fiq_ctrl;
  localparam logic [7:0] A_ACK = 8'h18, A_CLR = 8'h1C, A_EOI = 8'h28,
                         A_PRIO = 8'h2C, A_SVC = 8'h4C;
  localparam logic [31:0] DFLT = 32'hFFFF_FFFF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  req = '0;
  logic        sel = 1'b0, we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        fiq;
  int          checks = 0, fails = 0;
  bit          done = 0;

  always #10 clk = ~clk;

  fiq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .req_i(req), .bus_sel_i(sel), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata), .fiq_o(fiq)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); sel = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); sel = 0; we = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk); sel = 1; we = 0; addr = a;
    #2 d = rdata;
    @(negedge clk); sel = 0;
  endtask

  task automatic drive_req(logic [7:0] v);
    @(negedge clk); req = v;
    @(negedge clk); #1;
  endtask

  task automatic all_prio(logic [2:0] v);
    for (int i = 0; i < 8; i++) wr(A_PRIO + 8'(4 * i), 32'(v));
  endtask

  function automatic logic [31:0] vec(int i);
    return 32'hFFFF_FFF8 | 32'(i);
  endfunction

  task automatic t_reset();
    logic [31:0] d;
    check("R1 fiq after reset", 32'(fiq), 0);
    rd(A_SVC, d); check("R1 in-service reset", d, 0);
    for (int i = 0; i < 8; i++) begin
      rd(A_PRIO + 8'(4 * i), d); check("R1 priority reset", d, 7);
    end
    rd(A_ACK, d); check("R3 idle acknowledge", d, DFLT);
  endtask

  task automatic t_prio_regs();
    logic [31:0] d;
    for (int i = 0; i < 8; i++) wr(A_PRIO + 8'(4 * i), 32'hFFFF_FFF8 | 32'((i + 3) % 8));
    for (int i = 0; i < 8; i++) begin
      rd(A_PRIO + 8'(4 * i), d); check("R9 priority layout", d, 32'((i + 3) % 8));
    end
  endtask

  task automatic t_single();
    logic [31:0] d;
    all_prio(3'd4);
    drive_req(8'h08);
    check("R2 rise pends", 32'(fiq), 1);
    rd(A_ACK, d); check("R3 vector 3", d, vec(3));
    rd(A_SVC, d); check("R5 in-service set", d, 32'h08);
    check("R5 pending cleared", 32'(fiq), 0);
    wr(A_EOI, 32'h0);
    #1 check("R2 held level not re-pended", 32'(fiq), 0);
    rd(A_ACK, d); check("R3 default after retire", d, DFLT);
    drive_req(8'h00);
    drive_req(8'h08);
    check("R2 new edge pends", 32'(fiq), 1);
    rd(A_ACK, d); check("R3 vector 3 again", d, vec(3));
    wr(A_EOI, 32'h0);
    drive_req(8'h00);
  endtask

  task automatic t_tie();
    logic [31:0] d;
    all_prio(3'd4);
    drive_req(8'h24);
    rd(A_ACK, d); check("R4 tie lower index", d, vec(2));
    #1 check("R6 equal priority blocked", 32'(fiq), 0);
    wr(A_EOI, 32'h0);
    #1 check("R6 released after retire", 32'(fiq), 1);
    rd(A_ACK, d); check("R4 second of tie", d, vec(5));
    rd(A_SVC, d); check("R5 in-service 5", d, 32'h20);
    wr(A_EOI, 32'h0);
    drive_req(8'h00);
  endtask

  task automatic t_priority();
    logic [31:0] d;
    all_prio(3'd4);
    wr(A_PRIO + 8'(4 * 6), 1);
    wr(A_PRIO + 8'(4 * 1), 3);
    drive_req(8'h42);
    rd(A_ACK, d); check("R4 lowest code wins", d, vec(6));
    #1 check("R6 less urgent blocked", 32'(fiq), 0);
    wr(A_EOI, 32'h0);
    rd(A_ACK, d); check("R4 next code", d, vec(1));
    wr(A_EOI, 32'h0);
    drive_req(8'h00);
    drive_req(8'h01);
    drive_req(8'h00);
    check("R2 falling edge keeps pending", 32'(fiq), 1);
    rd(A_ACK, d); check("R2 vector after fall", d, vec(0));
    wr(A_EOI, 32'h0);
  endtask

  task automatic t_nesting();
    logic [31:0] d;
    all_prio(3'd4);
    wr(A_PRIO + 8'(4 * 0), 5);
    wr(A_PRIO + 8'(4 * 6), 2);
    drive_req(8'h01);
    rd(A_ACK, d); check("R3 vector 0", d, vec(0));
    drive_req(8'h41);
    check("R6 nesting raises", 32'(fiq), 1);
    rd(A_ACK, d); check("R6 nested vector 6", d, vec(6));
    rd(A_SVC, d); check("R5 nested in-service", d, 32'h41);
    drive_req(8'h51);
    check("R6 not more urgent", 32'(fiq), 0);
    rd(A_ACK, d); check("R3 blocked gives default", d, DFLT);
    rd(A_SVC, d); check("R5 default read leaves set", d, 32'h41);
    wr(A_EOI, 32'h0);
    rd(A_SVC, d); check("R7 most urgent retired", d, 32'h01);
    #1 check("R6 unblocked", 32'(fiq), 1);
    rd(A_ACK, d); check("R4 vector 4", d, vec(4));
    wr(A_EOI, 32'h0);
    rd(A_SVC, d); check("R7 retire input 4", d, 32'h01);
    wr(A_EOI, 32'h0);
    rd(A_SVC, d); check("R7 retire input 0", d, 32'h00);
    wr(A_EOI, 32'h0);
    rd(A_SVC, d); check("R7 empty retire no effect", d, 32'h00);
    drive_req(8'h00);
  endtask

  task automatic t_clear();
    logic [31:0] d;
    all_prio(3'd4);
    drive_req(8'h08);
    drive_req(8'h00);
    wr(A_CLR, 32'h0000_0003);
    #1 check("R8 cleared no fiq", 32'(fiq), 0);
    rd(A_ACK, d); check("R8 cleared default", d, DFLT);
    rd(A_SVC, d); check("R8 nothing serviced", d, 0);
    wr(A_SVC, 32'hFF);
    rd(A_SVC, d); check("R10 write ignored", d, 0);
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    t_reset();
    t_prio_regs();
    t_single();
    t_tie();
    t_priority();
    t_nesting();
    t_clear();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule